// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from a group of sources. Each source has its own programmable priority and enable. Every cycle it picks the pending, enabled source with the highest priority. If that priority is strictly above the current preemption threshold, it drives an active-low request line to the processor. The threshold is the larger of two values:

- the priority of the service routine now running, which hardware tracks;
- a forced floor that software may raise.

When the processor reads the dedicated vector location, the block does four things: it returns the start address of the winning routine, pulses an acknowledge strobe, pushes the running priority onto a small nesting stack and adopts the new priority. An access to the exit location pops the stack and pulses an exit strobe. A control register holds a global enable and a vector-table enable. Clearing the global enable stops new requests, but a request that is already on the line stays there until it is served.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A request raised before a clock edge is registered at that edge and appears on `irq_n` (low) after the second edge. It is never visible after only one edge.
- R2: `pend_valid`, `pend_prio` and `pend_src` report the pending, enabled source with the highest priority. On equal priorities the lower source number wins. A source whose enable is 0 is never reported. With nothing pending they read 0.
- R3: Control register (`wr_sel`=0): bit 7 is the global enable and bit 6 is the table enable; 1 enables. With bit 7 at 0 no new request is raised, but a request already on `irq_n` stays low while its condition holds.
- R4: `irq_n` goes low only when `pend_prio` is strictly greater than the larger of `act_prio` and `frc_prio`. `frc_prio` is written with `wr_sel`=1.
- R5: `act_prio` changes only through acknowledge and exit. Writes to `wr_sel`=1, 2 or 3 leave it unchanged.
- R6: With bit 6 set, a pending source and the stack not full, `vec_ack` does the following at the next edge:
  - `vec_addr` becomes VEC_BASE + 4 × `pend_src`;
  - `ack_strobe` is high for one cycle;
  - `act_prio` takes the value of `pend_prio`;
  - the old `act_prio` is pushed onto the stack.
- R7: `vec_exit` pops the stack into `act_prio` and pulses `exit_strobe` for one cycle. When the stack is empty it has no effect.
- R8: With bit 6 clear, `vec_ack` sets `vec_addr` to 0, gives no strobe and leaves `act_prio` unchanged. `vec_exit` has no effect.
- R9: The stack holds 8 entries. An acknowledge with the stack full is refused: `vec_addr` becomes 0, there is no strobe and `act_prio` is unchanged.
- R10: When `vec_ack` and `vec_exit` arrive in the same cycle, the acknowledge is served and the exit is ignored.
- R11: After reset, `irq_n` is 1 and the enables, priorities, `act_prio`, `frc_prio` and the stack are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Level requests, one per source |
| cfg_we | input | 1 | Write strobe for one source's priority and enable |
| cfg_idx | input | SRC_W | Source number being configured |
| cfg_prio | input | PRIO_W | Priority to store |
| cfg_en | input | 1 | Enable to store |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 forced floor, 2 and 3 ignored |
| wr_data | input | 8 | Register write data |
| vec_ack | input | 1 | Processor read of the vector location |
| vec_exit | input | 1 | Processor access of the exit location |
| irq_n | output | 1 | Active-low request to the processor |
| ctrl_q | output | 8 | Control register readback |
| act_prio | output | PRIO_W | Priority of the running routine |
| frc_prio | output | PRIO_W | Forced floor |
| pend_valid | output | 1 | A pending, enabled source exists |
| pend_prio | output | PRIO_W | Priority of the winning source |
| pend_src | output | SRC_W | Number of the winning source |
| vec_addr | output | ADDR_W | Routine start address from the last vector read |
| ack_strobe | output | 1 | One-cycle acknowledge pulse |
| exit_strobe | output | 1 | One-cycle exit pulse |

## Verification
An acknowledge and an exit can land in the same cycle. Each of them moves the nesting stack and `act_prio`, in opposite directions. The bench sets up this collision by asserting `vec_ack` and `vec_exit` together while the stack holds two entries and a higher source is pending. It then expects three things: an acknowledge strobe, no exit strobe, and `act_prio` equal to the acknowledged priority. The exits that follow must unwind the stack in the exact reverse order of the entries. A second overlap is a global-enable clear written while a request is on the line. It is judged by `irq_n` staying low until the acknowledge.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int CTRL_GE_BIT = 7;
  localparam int CTRL_TE_BIT = 6;
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_FLOOR = 2'd1;
endpackage

// File: rtl/pic_src_table.sv
module pic_src_table #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 6,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        src_req,
  input  logic                      cfg_we,
  input  logic [SRC_W-1:0]          cfg_idx,
  input  logic [PRIO_W-1:0]         cfg_prio,
  input  logic                      cfg_en,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic [NUM_SRC-1:0]        req_q
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [PRIO_W-1:0] prio_r;
    logic              en_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_r   <= '0;
        en_r     <= 1'b0;
        req_q[g] <= 1'b0;
      end else begin
        if (cfg_we && cfg_idx == SRC_W'(g)) begin
          prio_r <= cfg_prio;
          en_r   <= cfg_en;
        end
        req_q[g] <= src_req[g] & en_r;
      end
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_r;

    // R2
    masked_src_chk: assert property (@(posedge clk) disable iff (rst)
      !en_r |=> !req_q[g]);
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 6,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      win_valid,
  output logic [PRIO_W-1:0]         win_prio,
  output logic [SRC_W-1:0]          win_src
);
  always_comb begin
    win_valid = 1'b0;
    win_prio  = '0;
    win_src   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
        win_valid = 1'b1;
        win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
        win_src   = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_nest_stack.sv
module pic_nest_stack #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  sp;
  logic [CNT_W-1:0]  sp_m1;

  assign full  = (sp == CNT_W'(DEPTH));
  assign empty = (sp == '0);
  assign sp_m1 = sp - 1'b1;
  assign dout  = mem[sp_m1[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[sp[PTR_W-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (push && !full) sp <= sp + 1'b1;
    else if (pop && !empty) sp <= sp - 1'b1;
  end

  // R9
  sp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sp <= CNT_W'(DEPTH));
  // R10
  no_dual_op_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import pic_pkg::*; #(
  parameter int NUM_SRC    = 16,
  parameter int PRIO_W     = 6,
  parameter int NEST_DEPTH = 8,
  parameter int ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = 'h400,
  localparam int SRC_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               cfg_we,
  input  logic [SRC_W-1:0]   cfg_idx,
  input  logic [PRIO_W-1:0]  cfg_prio,
  input  logic               cfg_en,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [7:0]         wr_data,
  input  logic               vec_ack,
  input  logic               vec_exit,
  output logic               irq_n,
  output logic [7:0]         ctrl_q,
  output logic [PRIO_W-1:0]  act_prio,
  output logic [PRIO_W-1:0]  frc_prio,
  output logic               pend_valid,
  output logic [PRIO_W-1:0]  pend_prio,
  output logic [SRC_W-1:0]   pend_src,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic               ack_strobe,
  output logic               exit_strobe
);
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]        req_q;
  logic                      win_valid;
  logic [PRIO_W-1:0]         win_prio;
  logic [SRC_W-1:0]          win_src;
  logic                      ge_q, te_q;
  logic [PRIO_W-1:0]         act_q, frc_q, thr;
  logic                      irq_n_q;
  logic                      stk_full, stk_empty;
  logic [PRIO_W-1:0]         stk_top;
  logic                      ack_fire, exit_fire;

  pic_src_table #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_table (
    .clk(clk), .rst(rst), .src_req(src_req), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_prio(cfg_prio), .cfg_en(cfg_en), .prio_flat(prio_flat), .req_q(req_q));

  pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req(req_q), .prio_flat(prio_flat), .win_valid(win_valid),
    .win_prio(win_prio), .win_src(win_src));

  assign ack_fire  = vec_ack && te_q && pend_valid && !stk_full;
  assign exit_fire = vec_exit && !vec_ack && te_q && !stk_empty;

  pic_nest_stack #(.DEPTH(NEST_DEPTH), .DATA_W(PRIO_W)) u_stack (
    .clk(clk), .rst(rst), .push(ack_fire), .pop(exit_fire), .din(act_q),
    .dout(stk_top), .full(stk_full), .empty(stk_empty));

  assign thr = (act_q > frc_q) ? act_q : frc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ge_q <= 1'b0;
      te_q <= 1'b0;
      frc_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_CTRL) begin
        ge_q <= wr_data[CTRL_GE_BIT];
        te_q <= wr_data[CTRL_TE_BIT];
      end else if (wr_sel == SEL_FLOOR) begin
        frc_q <= wr_data[PRIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_q    <= 1'b1;
      pend_valid <= 1'b0;
      pend_prio  <= '0;
      pend_src   <= '0;
    end else begin
      irq_n_q    <= !(win_valid && (win_prio > thr) && (ge_q || !irq_n_q));
      pend_valid <= win_valid;
      pend_prio  <= win_prio;
      pend_src   <= win_src;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q       <= '0;
      vec_addr    <= '0;
      ack_strobe  <= 1'b0;
      exit_strobe <= 1'b0;
    end else begin
      ack_strobe  <= ack_fire;
      exit_strobe <= exit_fire;
      if (vec_ack)
        vec_addr <= ack_fire ? VEC_BASE + (ADDR_W'(pend_src) << 2) : '0;
      if (ack_fire)       act_q <= pend_prio;
      else if (exit_fire) act_q <= stk_top;
    end
  end

  assign irq_n    = irq_n_q;
  assign act_prio = act_q;
  assign frc_prio = frc_q;
  assign ctrl_q   = {ge_q, te_q, 6'b0};

  // R3
  new_req_needs_ge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n_q) |-> $past(ge_q));
  // R4
  irq_above_thr_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n_q |-> (pend_prio > $past(thr)));
  // R5
  act_hw_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> $past(vec_ack || vec_exit));
  // R8
  ack_needs_te_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_strobe || exit_strobe) |-> $past(te_q));
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ack_strobe && exit_strobe));
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  localparam int N = 16;
  localparam int PW = 6;
  localparam int BASE = 'h400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_req = '0;
  logic cfg_we = 0, cfg_en = 0, wr_en = 0, vec_ack = 0, vec_exit = 0;
  logic [3:0] cfg_idx = '0;
  logic [PW-1:0] cfg_prio = '0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic irq_n, pend_valid, ack_strobe, exit_strobe;
  logic [7:0] ctrl_q;
  logic [PW-1:0] act_prio, frc_prio, pend_prio;
  logic [3:0] pend_src;
  logic [31:0] vec_addr;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .src_req(src_req), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_prio(cfg_prio), .cfg_en(cfg_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .vec_ack(vec_ack), .vec_exit(vec_exit), .irq_n(irq_n),
    .ctrl_q(ctrl_q), .act_prio(act_prio), .frc_prio(frc_prio),
    .pend_valid(pend_valid), .pend_prio(pend_prio), .pend_src(pend_src),
    .vec_addr(vec_addr), .ack_strobe(ack_strobe), .exit_strobe(exit_strobe));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int actual, input int expected);
    n_run++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; step(1); wr_en = 0;
  endtask

  task automatic cfg(input int idx, input int p, input logic en);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_prio = PW'(p); cfg_en = en; step(1); cfg_we = 0;
  endtask

  task automatic do_ack(input logic with_exit);
    vec_ack = 1; vec_exit = with_exit; step(1); vec_ack = 0; vec_exit = 0;
  endtask

  task automatic do_exit();
    vec_exit = 1; step(1); vec_exit = 0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3); rst = 0; step(1);
    // R11 reset state
    chk("R11 irq_n", irq_n, 1);
    chk("R11 act", act_prio, 0);
    chk("R11 frc", frc_prio, 0);
    chk("R11 ctrl", ctrl_q, 0);
    chk("R11 pend_valid", pend_valid, 0);

    wreg(2'd0, 8'hC0);
    chk("R3 ctrl readback", ctrl_q, 8'hC0);

    // R1/R2 single-source sweep
    for (int i = 0; i < N; i++) cfg(i, (i*5+3) % 64, 1'b1);
    for (int i = 0; i < N; i++) begin
      src_req = N'(1) << i;
      step(1);
      chk("R1 one edge", irq_n, 1);
      step(1);
      chk("R1 two edges", irq_n, 0);
      chk("R2 src", pend_src, i);
      chk("R2 prio", pend_prio, (i*5+3) % 64);
      src_req = '0; step(3);
    end

    // R2 tie sweep: all equal priority, lower number wins
    for (int i = 0; i < N; i++) cfg(i, 7, 1'b1);
    for (int i = 0; i < N; i++)
      for (int j = i+1; j < N; j++) begin
        src_req = (N'(1) << i) | (N'(1) << j);
        step(2);
        chk("R2 tie", pend_src, i);
        src_req = '0;
      end
    step(2);

    // R2 disabled source masked
    cfg(4, 9, 1'b0);
    src_req = N'(1) << 4; step(3);
    chk("R2 disabled valid", pend_valid, 0);
    chk("R2 disabled irq", irq_n, 1);
    src_req = '0; step(2);

    for (int i = 0; i < N; i++) cfg(i, i+1, 1'b1);

    // R6 acknowledge
    src_req = N'(1) << 2; step(2);
    chk("R6 irq before ack", irq_n, 0);
    do_ack(1'b0);
    chk("R6 ack strobe", ack_strobe, 1);
    chk("R6 vec_addr", vec_addr, BASE + 8);
    chk("R6 act", act_prio, 3);
    step(1);
    chk("R6 strobe one cycle", ack_strobe, 0);
    chk("R6 irq released", irq_n, 1);

    // R4 forced floor
    wreg(2'd1, 8'd5);
    src_req = src_req | (N'(1) << 4); step(3);
    chk("R4 equal to floor", irq_n, 1);
    chk("R5 floor write keeps act", act_prio, 3);
    src_req = src_req | (N'(1) << 5); step(2);
    chk("R4 above floor", irq_n, 0);
    src_req = src_req & ~(N'(1) << 5); step(3);
    chk("R4 back below", irq_n, 1);
    wreg(2'd2, 8'h3F); wreg(2'd3, 8'h3F);
    chk("R5 sel2/3 ignored", act_prio, 3);
    wreg(2'd1, 8'd0); step(2);
    chk("R4 floor cleared", irq_n, 0);

    // R3 global enable clear while asserted
    wreg(2'd0, 8'h40); step(2);
    chk("R3 held low", irq_n, 0);
    do_ack(1'b0);
    chk("R3 ack act", act_prio, 5);
    step(1);
    src_req = src_req | (N'(1) << 9); step(3);
    chk("R3 no new request", irq_n, 1);
    wreg(2'd0, 8'hC0); step(1);
    chk("R3 re-enabled", irq_n, 0);

    // R10 ack and exit together
    do_ack(1'b1);
    chk("R10 ack strobe", ack_strobe, 1);
    chk("R10 exit strobe", exit_strobe, 0);
    chk("R10 act", act_prio, 10);

    // R7 exit unwinding
    src_req = '0; step(2);
    do_exit(); chk("R7 pop1", act_prio, 5); chk("R7 strobe", exit_strobe, 1);
    do_exit(); chk("R7 pop2", act_prio, 3);
    do_exit(); chk("R7 pop3", act_prio, 0);
    do_exit(); chk("R7 empty strobe", exit_strobe, 0); chk("R7 empty act", act_prio, 0);

    // R8 table disabled
    wreg(2'd0, 8'h80);
    src_req = N'(1) << 3; step(2);
    do_ack(1'b0);
    chk("R8 no strobe", ack_strobe, 0);
    chk("R8 vec_addr", vec_addr, 0);
    chk("R8 act", act_prio, 0);
    chk("R8 irq stays", irq_n, 0);
    src_req = '0; wreg(2'd0, 8'hC0); step(2);

    // R9 nesting to full depth
    for (int k = 0; k < 8; k++) begin
      src_req = src_req | (N'(1) << k); step(2);
      do_ack(1'b0);
      chk("R9 nest act", act_prio, k+1);
      step(1);
    end
    src_req = src_req | (N'(1) << 8); step(2);
    chk("R9 irq when full", irq_n, 0);
    do_ack(1'b0);
    chk("R9 refused strobe", ack_strobe, 0);
    chk("R9 refused addr", vec_addr, 0);
    chk("R9 refused act", act_prio, 8);
    src_req = '0; step(2);
    for (int k = 7; k >= 0; k--) begin
      do_exit();
      chk("R9 unwind", act_prio, k);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule